// File: doc/BRIEF.md
# Timed Read Queue

This block is a single-clock first-in first-out store with a read controller in front of it. Each read is a transaction. The requester raises a strobe and supplies a signed wait limit. The controller then holds the request open until an entry is present or the limit runs out. Either way it finishes with a one-cycle completion pulse. The pulse carries the oldest entry, or a zero value with a timed-out flag.

A limit of zero gives a poll that always answers in the cycle after the request is sampled. A positive limit bounds the wait to that many cycles. A negative limit waits with no bound. Producers push entries through a plain write-enable port and watch the full flag. A synchronous clear discards every stored entry at any time.

Top module: `fifo_timed_read`

## Requirements
- R1: A successful read returns the oldest stored entry and removes it, so entries leave in the order they were written.
- R2: A request sampled at clock edge E0 with a wait limit of 0 while the store is empty completes with rd_done high after E0 and rd_timed_out high.
- R3: With a positive limit N and no entry arriving, rd_done and rd_timed_out go high after edge EN, the N-th edge after the accepting edge E0.
- R4: Any negative limit never expires: the read completes only once an entry is stored, and then completes successfully.
- R5: An entry written at edge Ew during a pending wait is returned with rd_done high after edge Ew+1. If that is also the cycle in which the limit would run out, success wins.
- R6: rd_done is high for exactly one cycle per completed request. Whenever rd_timed_out is high, rd_done is also high and rd_elem is zero.
- R7: A request is taken only while no read is pending. Strobes and changes of rd_timeout during a pending read have no effect, because the limit is captured at acceptance.
- R8: clr empties the store at the next edge and takes priority over a write in the same cycle. A pending read keeps counting down its remaining limit.
- R9: full is high while DEPTH entries are held, and writes while full are dropped.
- R10: A write and a successful read in the same cycle on a non-empty store both take effect.
- R11: After reset, rd_done, rd_timed_out and full are low and the store is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous discard of all stored entries |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Entry to store |
| full | output | 1 | Store holds DEPTH entries |
| rd_req | input | 1 | Read request strobe |
| rd_timeout | input | TW | Signed wait limit in cycles (0 poll, negative unbounded) |
| rd_done | output | 1 | One-cycle completion pulse |
| rd_elem | output | DW | Returned entry, zero on timeout |
| rd_timed_out | output | 1 | Completion without an entry |

## Verification
A wrong pointer or occupancy count shows up at the ports within one transaction. A read returns an out-of-order value, full rises at the wrong fill level, or a poll on a store that should be empty returns data. A countdown that is off by one shifts the completion pulse by one cycle, and the latency sweep catches that directly. A controller that escapes its waiting state early or late gives an extra pulse or a missing one, and the bench sees this in the cycles right after each transaction.

// File: rtl/ftr_pkg.sv
package ftr_pkg;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_WAIT = 1'b1
  } rd_state_e;

  typedef enum logic [1:0] {
    TM_NOW     = 2'd0,
    TM_COUNT   = 2'd1,
    TM_FOREVER = 2'd2
  } tmo_mode_e;

  // Classify a sign-extended wait limit.
  function automatic tmo_mode_e classify(input logic signed [31:0] t);
    if (t < 0)       return TM_FOREVER;
    else if (t == 0) return TM_NOW;
    else             return TM_COUNT;
  endfunction

endpackage

// File: rtl/ftr_store.sv
module ftr_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push_req,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] level
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (level == '0);
  assign full    = (level == CW'(DEPTH));
  assign push_ok = push_req && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= ptr_inc(wptr);
      if (pop_ok)  rptr <= ptr_inc(rptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/ftr_wait_timer.sv
module ftr_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          dec,
  output logic [TW-1:0] cnt,
  output logic          last
);

  assign last = (cnt == TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt <= '0;
    else if (load)                  cnt <= load_val;
    else if (dec && cnt != '0)      cnt <= cnt - 1'b1;
  end

endmodule

// File: rtl/ftr_read_ctrl.sv
module ftr_read_ctrl
  import ftr_pkg::*;
#(
  parameter int DW = 8,
  parameter int TW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic signed [TW-1:0] tmo,
  input  logic                 avail,
  input  logic [DW-1:0]        head,
  input  logic                 tmr_last,
  output logic                 tmr_load,
  output logic [TW-1:0]        tmr_val,
  output logic                 tmr_dec,
  output logic                 pop,
  output logic                 accept,
  output logic                 idle,
  output logic                 fin_ok,
  output logic                 fin_to,
  output logic                 done,
  output logic [DW-1:0]        elem,
  output logic                 timed_out
);

  rd_state_e state, nxt;
  logic      forever_q, forever_nxt;
  tmo_mode_e mode;

  assign mode    = classify(32'(tmo));
  assign idle    = (state == S_IDLE);
  assign accept  = idle && req;
  assign tmr_val = TW'(tmo);

  always_comb begin
    nxt         = state;
    forever_nxt = forever_q;
    pop         = 1'b0;
    fin_ok      = 1'b0;
    fin_to      = 1'b0;
    tmr_load    = 1'b0;
    tmr_dec     = 1'b0;
    case (state)
      S_IDLE: begin
        if (req) begin
          if (avail) begin
            pop    = 1'b1;
            fin_ok = 1'b1;
          end else begin
            case (mode)
              TM_NOW: fin_to = 1'b1;
              TM_FOREVER: begin
                nxt         = S_WAIT;
                forever_nxt = 1'b1;
              end
              default: begin
                nxt         = S_WAIT;
                forever_nxt = 1'b0;
                tmr_load    = 1'b1;
              end
            endcase
          end
        end
      end
      default: begin
        if (avail) begin
          pop    = 1'b1;
          fin_ok = 1'b1;
          nxt    = S_IDLE;
        end else if (!forever_q && tmr_last) begin
          fin_to = 1'b1;
          nxt    = S_IDLE;
        end else if (!forever_q) begin
          tmr_dec = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      forever_q <= 1'b0;
      done      <= 1'b0;
      elem      <= '0;
      timed_out <= 1'b0;
    end else begin
      state     <= nxt;
      forever_q <= forever_nxt;
      done      <= fin_ok || fin_to;
      elem      <= fin_ok ? head : '0;
      timed_out <= fin_to;
    end
  end

endmodule

// File: rtl/fifo_timed_read.sv
module fifo_timed_read #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int TW    = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 wr_en,
  input  logic [DW-1:0]        wr_data,
  output logic                 full,
  input  logic                 rd_req,
  input  logic signed [TW-1:0] rd_timeout,
  output logic                 rd_done,
  output logic [DW-1:0]        rd_elem,
  output logic                 rd_timed_out
);

  // Named internal events, also observed by the bound checker.
  logic          empty, avail, pop, accept, idle, fin_ok, fin_to;
  logic          tmr_load, tmr_dec, tmr_last;
  logic [TW-1:0] tmr_val, tmr_cnt;
  logic [DW-1:0] head;
  logic [CW-1:0] level;

  assign avail = !empty && !clr;

  ftr_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push_req(wr_en), .pop(pop), .din(wr_data),
    .head(head), .empty(empty), .full(full), .level(level)
  );

  ftr_wait_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .dec(tmr_dec), .cnt(tmr_cnt), .last(tmr_last)
  );

  ftr_read_ctrl #(.DW(DW), .TW(TW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(rd_req), .tmo(rd_timeout),
    .avail(avail), .head(head), .tmr_last(tmr_last),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_dec(tmr_dec),
    .pop(pop), .accept(accept), .idle(idle),
    .fin_ok(fin_ok), .fin_to(fin_to),
    .done(rd_done), .elem(rd_elem), .timed_out(rd_timed_out)
  );

endmodule

// File: rtl/ftr_checker.sv
module ftr_checker #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int TW    = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clr,
  input logic                 wr_en,
  input logic                 full,
  input logic signed [TW-1:0] rd_timeout,
  input logic                 rd_done,
  input logic [DW-1:0]        rd_elem,
  input logic                 rd_timed_out,
  input logic                 pop,
  input logic                 accept,
  input logic                 avail,
  input logic                 fin_ok,
  input logic                 fin_to,
  input logic [CW-1:0]        level
);

  a_r1_pop_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> level != '0);

  a_r1_pop_returns_data: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> rd_done && !rd_timed_out);

  a_r2_zero_limit_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rd_timeout == '0) |=> rd_done);

  a_r6_timeout_zero_elem: assert property (@(posedge clk) disable iff (!rst_n)
    rd_timed_out |-> (rd_done && rd_elem == '0));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(fin_ok || fin_to) |=> !rd_done);

  a_r6_finish_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_ok || fin_to) |=> rd_done);

  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> level == '0);

  a_r8_clear_blocks_pop: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !avail);

  a_r9_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !pop && !clr) |=> $stable(level));

  a_r10_rw_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full && pop && !clr) |=> $stable(level));

endmodule

bind fifo_timed_read ftr_checker #(.DW(DW), .DEPTH(DEPTH), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .full(full),
  .rd_timeout(rd_timeout), .rd_done(rd_done), .rd_elem(rd_elem),
  .rd_timed_out(rd_timed_out), .pop(pop), .accept(accept), .avail(avail),
  .fin_ok(fin_ok), .fin_to(fin_to), .level(level)
);

// File: tb/sim_fifo_timed_read.sv
`timescale 1ns/1ps
module sim_fifo_timed_read;

  localparam int DW    = 8;
  localparam int DEPTH = 8;
  localparam int TW    = 16;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 clr = 1'b0;
  logic                 wr_en = 1'b0;
  logic [DW-1:0]        wr_data = '0;
  logic                 full;
  logic                 rd_req = 1'b0;
  logic signed [TW-1:0] rd_timeout = '0;
  logic                 rd_done;
  logic [DW-1:0]        rd_elem;
  logic                 rd_timed_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fifo_timed_read #(.DW(DW), .DEPTH(DEPTH), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
    .full(full), .rd_req(rd_req), .rd_timeout(rd_timeout),
    .rd_done(rd_done), .rd_elem(rd_elem), .rd_timed_out(rd_timed_out)
  );

  function automatic logic [DW-1:0] vpat(input int i);
    return DW'((i * 37 + 5) & 255);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [DW-1:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // ev_kind: 0 none, 1 write ev_val, 2 clear, 3 stray strobe with new limit
  task automatic run_read(input int t, input int ev_kind, input int ev_at,
                          input logic [DW-1:0] ev_val,
                          output logic [DW-1:0] e, output logic to,
                          output int lat);
    @(negedge clk); rd_req = 1'b1; rd_timeout = TW'(t);
    @(negedge clk); rd_req = 1'b0; lat = 0;
    while (!rd_done && lat < 2000) begin
      if (lat == ev_at) begin
        case (ev_kind)
          1: begin wr_en = 1'b1; wr_data = ev_val; end
          2: clr = 1'b1;
          3: begin rd_req = 1'b1; rd_timeout = TW'(50); end
          default: ;
        endcase
      end
      @(negedge clk); wr_en = 1'b0; clr = 1'b0; rd_req = 1'b0; lat++;
    end
    e = rd_elem; to = rd_timed_out;
  endtask

  initial begin
    #500000;
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] e;
    logic to;
    int lat;

    repeat (3) @(negedge clk);
    check("R11 done after reset", int'(rd_done), 0);
    check("R11 timed_out after reset", int'(rd_timed_out), 0);
    check("R11 full after reset", int'(full), 0);
    rst_n = 1'b1;

    // R2 / R3: latency sweep on an empty store
    for (int n = 0; n <= 6; n++) begin
      run_read(n, 0, -1, '0, e, to, lat);
      check(n == 0 ? "R2 poll latency" : "R3 limit latency", lat, n);
      check("R3 timed out flag", int'(to), 1);
      check("R6 elem zero on timeout", int'(e), 0);
      @(negedge clk);
      check("R6 single pulse", int'(rd_done), 0);
    end

    // R4: negative limits wait for data
    run_read(-1, 1, 4, 8'h5A, e, to, lat);
    check("R4 unbounded latency", lat, 6);
    check("R4 unbounded not timed out", int'(to), 0);
    check("R4 unbounded elem", int'(e), 'h5A);
    run_read(-5, 1, 7, 8'hC3, e, to, lat);
    check("R4 negative latency", lat, 9);
    check("R4 negative elem", int'(e), 'hC3);

    // R5: data arriving during a bounded wait
    run_read(10, 1, 3, 8'h11, e, to, lat);
    check("R5 late data latency", lat, 5);
    check("R5 late data elem", int'(e), 'h11);
    run_read(5, 1, 3, 8'h22, e, to, lat);
    check("R5 tie latency", lat, 5);
    check("R5 tie success wins", int'(to), 0);
    check("R5 tie elem", int'(e), 'h22);
    run_read(4, 1, 3, 8'h33, e, to, lat);
    check("R3 expires before data", lat, 4);
    check("R3 expired flag", int'(to), 1);
    run_read(0, 0, -1, '0, e, to, lat);
    check("R1 stored after expiry", int'(e), 'h33);
    check("R1 stored not timed out", int'(to), 0);

    // R1 / R9: fill, overflow, drain in order
    for (int i = 0; i < DEPTH; i++) begin
      check("R9 not full while filling", int'(full), 0);
      wr(vpat(i));
    end
    check("R9 full at depth", int'(full), 1);
    wr(8'hEE);
    for (int i = 0; i < DEPTH; i++) begin
      run_read(0, 0, -1, '0, e, to, lat);
      check("R1 order", int'(e), int'(vpat(i)));
      check("R1 immediate", lat, 0);
    end
    run_read(0, 0, -1, '0, e, to, lat);
    check("R9 overflow dropped", int'(to), 1);

    // R8: clear
    wr(8'h01); wr(8'h02); wr(8'h03);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    run_read(0, 0, -1, '0, e, to, lat);
    check("R8 clear empties", int'(to), 1);
    @(negedge clk); clr = 1'b1; wr_en = 1'b1; wr_data = 8'h77;
    @(negedge clk); clr = 1'b0; wr_en = 1'b0;
    run_read(0, 0, -1, '0, e, to, lat);
    check("R8 clear beats write", int'(to), 1);
    run_read(6, 2, 2, '0, e, to, lat);
    check("R8 pending keeps counting", lat, 6);
    check("R8 pending times out", int'(to), 1);

    // R7: stray strobe and limit change while pending
    run_read(3, 3, 1, '0, e, to, lat);
    check("R7 limit latched", lat, 3);
    check("R7 latched timeout flag", int'(to), 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R7 stray strobe ignored", int'(rd_done), 0);
    end

    // R10: write and read in the same cycle
    wr(8'hA1); wr(8'hA2);
    @(negedge clk); rd_req = 1'b1; rd_timeout = '0; wr_en = 1'b1; wr_data = 8'hA3;
    @(negedge clk); rd_req = 1'b0; wr_en = 1'b0;
    check("R10 same-cycle done", int'(rd_done), 1);
    check("R10 same-cycle elem", int'(rd_elem), 'hA1);
    run_read(0, 0, -1, '0, e, to, lat);
    check("R10 second", int'(e), 'hA2);
    run_read(0, 0, -1, '0, e, to, lat);
    check("R10 write kept", int'(e), 'hA3);
    check("R10 write kept flag", int'(to), 0);
    run_read(0, 0, -1, '0, e, to, lat);
    check("R10 then empty", int'(to), 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule